// File: doc/BRIEF.md
# Configuration Bitstream Header Parser

This block sits in front of a device-configuration path and inspects a configuration image as it streams past, one byte per accepted valid/ready transfer. It scans for the single sync byte that opens the data section and validates the tag byte that follows it. It then assembles the 24-bit count of configuration bits, which is spread over four bytes, and checks that the image is long enough to hold the bits it announces.

Software or a loader first places the total image length on `file_len` and pulses `start`. It then streams exactly that many bytes. One cycle after the final byte is taken, the parser pulses `done`. At that point `status`, `mark_idx` and `bit_count` hold the result, and they stay there until the next `start`. Whatever the outcome, the parser always takes the whole image, so an upstream source never stalls on an error.

Top module: `cfg_hdr_scan`

## Requirements
- R1: `mark_idx` reports the zero-based position of the first byte equal to 0xFF. Earlier bytes are consumed and discarded.
- R2: If none of the `file_len` bytes equals 0xFF, `status` is 1 (missing marker) and `mark_idx` stays 0.
- R3: The byte after the marker must carry 0x2 in bits 7..4. Any other value gives `status` 2 (corrupt header).
- R4: `bit_count` is formed as follows: bits 23..20 come from bits 3..0 of the tag byte, bits 19..12 from the next byte, bits 11..4 from the byte after that, and bits 3..0 from bits 7..4 of the fourth byte.
- R5: If `mark_idx` + floor(`bit_count`/8) exceeds `file_len`, `status` is 3 (too short). Equality is still a success, `status` 0.
- R6: If the image ends before the tag byte and all three following count bytes have arrived, `status` is 3. This includes a marker in the last byte.
- R7: After a result is known, the parser keeps taking bytes until `file_len` bytes in total have been taken. `done` is high for exactly the cycle after the last byte is taken, and `in_ready` is low from then on.
- R8: `start` latches `file_len` and clears `status`, `mark_idx` and `bit_count`. With `file_len` = 0, `done` follows one cycle later with `status` 1. While idle, `in_ready` is low and offered bytes have no effect.
- R9: A synchronous active-high `rst` returns the parser to idle with `done`, `status`, `mark_idx`, `bit_count` and `in_ready` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new image; latches `file_len` |
| file_len | input | 32 | Total image length in bytes |
| in_byte | input | 8 | Image byte |
| in_valid | input | 1 | `in_byte` is valid |
| in_ready | output | 1 | Parser takes a byte this cycle when valid |
| done | output | 1 | One-cycle pulse: result is final |
| status | output | 2 | 0 ok, 1 missing marker, 2 corrupt header, 3 too short |
| mark_idx | output | 32 | Position of the 0xFF marker |
| bit_count | output | 24 | Assembled configuration bit count |

## Verification
On every cycle, the assertions check the following: the marker position is captured from the byte counter at the moment a 0xFF byte is taken during search; a bad tag nibble is turned into the corrupt code; `done` only appears once the byte counter has reached the latched length; and the counter never passes that length. Whether the 24-bit count is assembled correctly, where the too-short boundary lies, and how each outcome behaves under stalled input can only be shown by the bench's whole-image scenarios. These scenarios compare `status`, `mark_idx` and `bit_count` against values the bench works out from the image it built.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int CNT_W = 24;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;
    localparam logic [3:0] TAG_NIB   = 4'h2;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_NOMARK  = 2'd1,
        ST_CORRUPT = 2'd2,
        ST_SHORT   = 2'd3
    } hdr_status_e;

    typedef enum logic [2:0] {
        P_IDLE   = 3'd0,
        P_SEARCH = 3'd1,
        P_TAG    = 3'd2,
        P_CNT1   = 3'd3,
        P_CNT2   = 3'd4,
        P_CNT3   = 3'd5,
        P_DRAIN  = 3'd6
    } phase_e;

endpackage

// File: rtl/hdr_pos_counter.sv
module hdr_pos_counter #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic [LEN_W-1:0] pos,
    output logic [LEN_W-1:0] len,
    output logic             at_last
);
    typedef struct packed {
        logic [LEN_W-1:0] pos;
        logic [LEN_W-1:0] len;
    } cnt_state_t;

    cnt_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.pos = '0;
            nxt_d.len = len_in;
        end else if (step) begin
            nxt_d.pos = cur_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign pos     = cur_q.pos;
    assign len     = cur_q.len;
    assign at_last = (({1'b0, cur_q.pos} + 1'b1) == {1'b0, cur_q.len});

    // R7: the byte counter never runs past the latched image length
    a_r7_pos_bound: assert property (@(posedge clk) disable iff (rst)
        cur_q.pos <= cur_q.len);

endmodule

// File: rtl/hdr_count_asm.sv
module hdr_count_asm
    import cfg_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  phase_e           phase,
    input  logic [7:0]       in_byte,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_next
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (take) begin
            unique case (phase)
                P_TAG:   cnt_d[23:20] = in_byte[3:0];
                P_CNT1:  cnt_d[19:12] = in_byte;
                P_CNT2:  cnt_d[11:4]  = in_byte;
                P_CNT3:  cnt_d[3:0]   = in_byte[7:4];
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt      = cnt_q;
    assign cnt_next = cnt_d;

    // R4: the middle byte of the count lands unchanged in bits 19..12
    a_r4_mid_field: assert property (@(posedge clk) disable iff (rst)
        (take && !clear && phase == P_CNT1) |=> cnt_q[19:12] == $past(in_byte));

endmodule

// File: rtl/hdr_len_check.sv
module hdr_len_check #(
    parameter int LEN_W = 32,
    parameter int CW    = 24
) (
    input  logic [LEN_W-1:0] mark,
    input  logic [CW-1:0]    bits,
    input  logic [LEN_W-1:0] len,
    output logic             fits
);
    localparam int SUM_W = LEN_W + 1;

    logic [CW-1:0]    bytes_need;
    logic [SUM_W-1:0] end_pos;

    always_comb begin
        bytes_need = bits >> 3;
        end_pos    = {1'b0, mark} + SUM_W'(bytes_need);
        fits       = (end_pos <= {1'b0, len});
    end

endmodule

// File: rtl/cfg_hdr_scan.sv
module cfg_hdr_scan
    import cfg_hdr_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] file_len,
    input  logic [7:0]       in_byte,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             done,
    output logic [1:0]       status,
    output logic [LEN_W-1:0] mark_idx,
    output logic [CNT_W-1:0] bit_count
);
    typedef struct packed {
        phase_e           phase;
        hdr_status_e      status;
        logic [LEN_W-1:0] mark;
        logic             done;
    } top_state_t;

    top_state_t cur_q, nxt_d;

    logic             take;
    logic             load;
    logic             clr_cnt;
    logic             finish;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] len_q;
    logic             at_last;
    logic [CNT_W-1:0] cnt_next;
    logic             fits;

    assign in_ready = (cur_q.phase != P_IDLE);
    assign take     = in_valid && in_ready;

    hdr_pos_counter #(.LEN_W(LEN_W)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len_in  (file_len),
        .step    (take),
        .pos     (pos),
        .len     (len_q),
        .at_last (at_last)
    );

    hdr_count_asm u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr_cnt),
        .take     (take),
        .phase    (cur_q.phase),
        .in_byte  (in_byte),
        .cnt      (bit_count),
        .cnt_next (cnt_next)
    );

    hdr_len_check #(.LEN_W(LEN_W), .CW(CNT_W)) u_chk (
        .mark (cur_q.mark),
        .bits (cnt_next),
        .len  (len_q),
        .fits (fits)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        load       = 1'b0;
        clr_cnt    = 1'b0;
        finish     = 1'b0;
        unique case (cur_q.phase)
            P_IDLE: begin
                if (start) begin
                    load         = 1'b1;
                    clr_cnt      = 1'b1;
                    nxt_d.status = ST_OK;
                    nxt_d.mark   = '0;
                    if (file_len == '0) begin
                        nxt_d.status = ST_NOMARK;
                        finish       = 1'b1;
                    end else begin
                        nxt_d.phase = P_SEARCH;
                    end
                end
            end
            P_SEARCH: begin
                if (take) begin
                    if (in_byte == SYNC_BYTE) begin
                        nxt_d.mark = pos;
                        if (at_last) begin
                            nxt_d.status = ST_SHORT;
                            finish       = 1'b1;
                        end else begin
                            nxt_d.phase = P_TAG;
                        end
                    end else if (at_last) begin
                        nxt_d.status = ST_NOMARK;
                        finish       = 1'b1;
                    end
                end
            end
            P_TAG: begin
                if (take) begin
                    if (in_byte[7:4] != TAG_NIB) begin
                        nxt_d.status = ST_CORRUPT;
                        if (at_last) finish = 1'b1;
                        else         nxt_d.phase = P_DRAIN;
                    end else if (at_last) begin
                        nxt_d.status = ST_SHORT;
                        finish       = 1'b1;
                    end else begin
                        nxt_d.phase = P_CNT1;
                    end
                end
            end
            P_CNT1, P_CNT2: begin
                if (take) begin
                    if (at_last) begin
                        nxt_d.status = ST_SHORT;
                        finish       = 1'b1;
                    end else begin
                        nxt_d.phase = (cur_q.phase == P_CNT1) ? P_CNT2 : P_CNT3;
                    end
                end
            end
            P_CNT3: begin
                if (take) begin
                    nxt_d.status = fits ? ST_OK : ST_SHORT;
                    if (at_last) finish = 1'b1;
                    else         nxt_d.phase = P_DRAIN;
                end
            end
            P_DRAIN: begin
                if (take && at_last) finish = 1'b1;
            end
            default: nxt_d.phase = P_IDLE;
        endcase
        if (finish) begin
            nxt_d.phase = P_IDLE;
            nxt_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign done     = cur_q.done;
    assign status   = cur_q.status;
    assign mark_idx = cur_q.mark;

    // R1: a sync byte taken during search records the counter position
    a_r1_mark_pos: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == P_SEARCH && take && in_byte == SYNC_BYTE)
        |=> mark_idx == $past(pos));

    // R3: a wrong tag nibble is reported as a corrupt header
    a_r3_bad_tag: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == P_TAG && take && in_byte[7:4] != TAG_NIB)
        |=> status == ST_CORRUPT);

    // R7: done only once the whole image has been taken
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
        done |-> (pos == len_q));

    // R7: no byte is taken in the cycle that reports the result
    a_r7_done_closed: assert property (@(posedge clk) disable iff (rst)
        done |-> !in_ready);

endmodule

// File: tb/cfg_hdr_scan_bench.sv
module cfg_hdr_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        nomark;
        logic [31:0] len;
        logic [31:0] pos;
        logic [7:0]  tag;
        logic [23:0] cnt;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'd40, 32'd3,  8'h20, 24'h000100},  // R5 fits
        '{1'b0, 32'd35, 32'd3,  8'h20, 24'h000100},  // R5 equality ok
        '{1'b0, 32'd34, 32'd3,  8'h20, 24'h000100},  // R5 one byte short
        '{1'b0, 32'd20, 32'd2,  8'h30, 24'h000000},  // R3 corrupt
        '{1'b1, 32'd10, 32'd0,  8'h00, 24'h000000},  // R2 no marker
        '{1'b0, 32'd12, 32'd0,  8'h2F, 24'h5ABCDE},  // R4 full count, short
        '{1'b0, 32'd6,  32'd5,  8'h20, 24'h000000},  // R6 marker last
        '{1'b0, 32'd8,  32'd5,  8'h20, 24'h000000},  // R6 count cut
        '{1'b0, 32'd5,  32'd3,  8'h1F, 24'h000000},  // R3 tag last byte
        '{1'b0, 32'd9,  32'd0,  8'h20, 24'h00004F},  // R4/R5 nonaligned
        '{1'b0, 32'd64, 32'd17, 8'hE0, 24'h000000}   // R7 long drain
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] file_len;
    logic [7:0]  in_byte;
    logic        in_valid;
    logic        in_ready;
    logic        done;
    logic [1:0]  status;
    logic [31:0] mark_idx;
    logic [23:0] bit_count;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_scan u_cfg_hdr_scan (
        .clk(clk), .rst(rst), .start(start), .file_len(file_len),
        .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
        .done(done), .status(status), .mark_idx(mark_idx), .bit_count(bit_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(vec_t v, int i);
        if (!v.nomark && i == int'(v.pos))   return 8'hFF;
        if (!v.nomark && i == int'(v.pos)+1) return {v.tag[7:4], v.cnt[23:20]};
        if (!v.nomark && i == int'(v.pos)+2) return v.cnt[19:12];
        if (!v.nomark && i == int'(v.pos)+3) return v.cnt[11:4];
        if (!v.nomark && i == int'(v.pos)+4) return {v.cnt[3:0], 4'h6};
        return 8'((i * 3) & 8'h7E);
    endfunction

    function automatic logic [1:0] exp_status(vec_t v);
        if (v.nomark)                     return 2'd1;
        if (v.pos + 1 >= v.len)           return 2'd3;
        if (v.tag[7:4] != 4'h2)           return 2'd2;
        if (v.pos + 5 > v.len)            return 2'd3;
        if (v.pos + (v.cnt >> 3) > v.len) return 2'd3;
        return 2'd0;
    endfunction

    task automatic run_file(vec_t v, bit gaps, int stall_at);
        int taken = 0;
        int cyc = 0;
        @(negedge clk);
        start = 1'b1; file_len = v.len;
        @(negedge clk);
        start = 1'b0;
        while (taken < int'(v.len)) begin
            in_valid = !(gaps && (cyc % 3 == 2)) && (cyc != stall_at);
            in_byte  = byte_at(v, taken);
            if (in_valid && in_ready) taken++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
    endtask

    task automatic check_result(vec_t v, string tag);
        logic [1:0] es;
        es = exp_status(v);
        check(done == 1'b1, "R7", {tag, " done"}, done, 1);
        check(status == es, (es == 2'd1) ? "R2" : (es == 2'd2) ? "R3" :
              (es == 2'd3) ? "R6" : "R5", {tag, " status"}, status, es);
        check(mark_idx == (v.nomark ? 32'd0 : v.pos), "R1", {tag, " mark"},
              mark_idx, v.nomark ? 0 : v.pos);
        if (!v.nomark && v.tag[7:4] == 4'h2 && v.pos + 5 <= v.len)
            check(bit_count == v.cnt, "R4", {tag, " count"}, bit_count, v.cnt);
        check(in_ready == 1'b0, "R7", {tag, " ready after done"}, in_ready, 0);
        @(negedge clk);
        check(done == 1'b0, "R7", {tag, " done one cycle"}, done, 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        rst = 1'b1; start = 1'b0; file_len = '0; in_byte = '0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(done == 0 && status == 0 && mark_idx == 0 && bit_count == 0,
              "R9", "reset outputs", {done, status, mark_idx[7:0]}, 0);
        check(in_ready == 1'b0, "R9", "reset ready", in_ready, 0);

        for (int k = 0; k < NVEC; k++) begin
            run_file(VECS[k], k[0], -1);
            check_result(VECS[k], $sformatf("vec%0d", k));
        end

        // R8: bytes offered while idle have no effect
        in_valid = 1'b1; in_byte = 8'hFF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R8", "idle ready", in_ready, 0);
        end
        in_valid = 1'b0;
        v = '{1'b1, 32'd7, 32'd0, 8'h00, 24'h0};
        run_file(v, 1'b0, 2);
        check_result(v, "R8 idle bytes ignored");

        // R8: zero length reports missing marker at once
        v = '{1'b1, 32'd0, 32'd0, 8'h00, 24'h0};
        run_file(v, 1'b0, -1);
        check_result(v, "R8 zero length");

        // R9: reset in mid-stream
        @(negedge clk);
        start = 1'b1; file_len = 32'd30;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b1; in_byte = 8'hFF;
        @(negedge clk);
        in_byte = 8'h23;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(in_ready == 0 && mark_idx == 0 && bit_count == 0 && status == 0,
              "R9", "mid-stream reset", {in_ready, mark_idx[7:0], bit_count[7:0]}, 0);

        // after reset the parser works again
        run_file(VECS[0], 1'b1, 4);
        check_result(VECS[0], "post-reset R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule